// File: doc/BRIEF.md
# Double-data-rate output serialiser

This block turns a stream of word pairs from the normal clock domain into one output bus that carries a new word on every clock edge. Each clock period the pair presented at the inputs is captured on the active edge. The first word of the pair is driven for the half-period that follows that edge. The second word is driven for the half-period after the next edge of the opposite polarity. The first word therefore always leaves before the second, whichever clock polarity is chosen as active.

An elaboration-time parameter picks the active edge: rising or falling. A synchronous reset, sampled on the active edge, replaces the captured pair with a reset constant given at a port. The pair offered while reset is sampled is discarded. A clock enable, when low, freezes the captured pair, so the bus keeps replaying the last pair. The output is the XOR of two registers, one updated on each edge. Only one of them changes at any edge, so the bus moves once per half-period with no combinational race against the clock.

Top module: `ddr_out_serialiser`

## Requirements
- R1: When the active edge samples `rst` low and `en` high, `dout` equals the captured `lo_word` from that active edge until the next opposite edge.
- R2: The `hi_word` captured at that active edge is on `dout` from the next opposite edge until the following active edge.
- R3: With `ACTIVE_RISING` = 1 the first word follows a rising clock edge and the second a falling one. With `ACTIVE_RISING` = 0 these two roles swap, and the first word still precedes the second in time.
- R4: An active edge that samples `rst` high drops the offered pair and loads `rst_val` as both words. `dout` equals that `rst_val` in the second half-period after that edge. It also equals `rst_val` in both half-periods of each later period, as long as `rst` keeps being sampled high.
- R5: An active edge that samples `en` low and `rst` low keeps the previous pair, so `dout` repeats the last two words.
- R6: `rst` takes priority over `en`: with both high at an active edge, the behaviour is as in R4.
- R7: `rst_val` is ignored at every active edge where `rst` is low. Changing it while reset is not sampled leaves `dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst | input | 1 | Synchronous reset, sampled on the active edge |
| en | input | 1 | Clock enable for the pair capture |
| lo_word | input | W | Word sent first, after the active edge |
| hi_word | input | W | Word sent second, after the opposite edge |
| rst_val | input | W | Constant loaded as both words on reset |
| dout | output | W | Double-data-rate output bus |

## Verification
The interesting coincidence is `rst` and `en` both high at the same active edge. The pair on the data inputs then competes with the reset constant. The bench provokes this with a directed stretch and with random single-cycle and multi-cycle reset pulses drawn while `en` is also random. It expects `rst_val` on the bus in each slot that R4 defines, and never the offered pair. A second instance with the falling edge active runs on the same stimulus, so each case is also judged with the opposite polarity.

// File: rtl/ddr_out_serialiser.sv
module ddr_out_serialiser #(
  parameter int W = 8,
  parameter bit ACTIVE_RISING = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] lo_word,
  input  logic [W-1:0] hi_word,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] dout
);

  logic         aclk;
  logic         rst_q;
  logic [W-1:0] pair_lo, pair_hi, nxt_lo, nxt_hi;
  logic [W-1:0] q_act, q_oth;

  assign aclk   = ACTIVE_RISING ? clk : ~clk;
  assign nxt_lo = rst ? rst_val : (en ? lo_word : pair_lo);
  assign nxt_hi = rst ? rst_val : (en ? hi_word : pair_hi);

  always_ff @(posedge aclk) begin
    rst_q   <= rst;
    pair_lo <= nxt_lo;
    pair_hi <= nxt_hi;
    q_act   <= rst ? rst_val : (nxt_lo ^ q_oth);
  end

  always_ff @(negedge aclk) begin
    q_oth <= rst_q ? '0 : (pair_hi ^ q_act);
  end

  assign dout = q_act ^ q_oth;

  // R1
  first_slot_chk: assert property (@(negedge aclk) disable iff (rst_q !== 1'b0)
    dout == pair_lo);

  // R2
  second_slot_chk: assert property (@(posedge aclk) disable iff ($isunknown(rst_q))
    dout == pair_hi);

  // R4
  reset_value_chk: assert property (@(posedge aclk) disable iff ($isunknown(rst_q))
    rst_q |-> dout == $past(rst_val));

  // R5
  hold_pair_chk: assert property (@(posedge aclk) disable iff (rst !== 1'b0)
    !en |=> ($stable(pair_lo) && $stable(pair_hi)));

endmodule

// File: tb/ddr_out_serialiser_tb.sv
`timescale 1ns/1ps
module ddr_out_serialiser_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic [W-1:0] lo = '0, hi = '0, rv = '1;
  logic [W-1:0] d_r, d_f;

  int checks = 0, fails = 0, n = 0;
  bit done = 1'b0;
  string tag = "";

  logic [W-1:0] r_e0, r_e1, f_e0, f_e1;
  bit r_skip, f_skip, r_prev = 1'b0, f_prev = 1'b0;
  string r_t0, r_t1;

  always #2.5 clk = ~clk;

  ddr_out_serialiser #(.W(W), .ACTIVE_RISING(1'b1)) u_dut (
    .clk(clk), .rst(rst), .en(en), .lo_word(lo), .hi_word(hi), .rst_val(rv), .dout(d_r));

  ddr_out_serialiser #(.W(W), .ACTIVE_RISING(1'b0)) u_dut_f (
    .clk(clk), .rst(rst), .en(en), .lo_word(lo), .hi_word(hi), .rst_val(rv), .dout(d_f));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cap_r();
    r_skip = rst && !r_prev;
    r_prev = rst;
    if (rst) begin
      r_e0 = rv; r_e1 = rv;
      r_t0 = en ? "R6" : "R4"; r_t1 = r_t0;
    end else if (en) begin
      r_e0 = lo; r_e1 = hi; r_t0 = "R1"; r_t1 = "R2";
    end else begin
      r_t0 = "R5"; r_t1 = "R5";
    end
    if (tag != "") begin r_t0 = tag; r_t1 = tag; end
  endtask

  task automatic cap_f();
    f_skip = rst && !f_prev;
    f_prev = rst;
    if (rst) begin f_e0 = rv; f_e1 = rv; end
    else if (en) begin f_e0 = lo; f_e1 = hi; end
  endtask

  // Entered 1.25 ns after a rising edge.
  task automatic step(input bit r, input bit e, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [W-1:0] v, input string t);
    #0.25;
    rst = r; en = e; lo = a; hi = b; rv = v; tag = t;
    @(negedge clk);
    cap_f();
    #1.25;
    if (n >= 2) begin
      if (!f_skip) chk("R3 falling-active first word", d_f, f_e0);
      chk(r_t1, d_r, r_e1);
    end
    @(posedge clk);
    cap_r();
    #1.25;
    if (n >= 2) begin
      if (!r_skip) chk(r_t0, d_r, r_e0);
      chk("R3 falling-active second word", d_f, f_e1);
    end
    n++;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250));
    @(posedge clk);
    #1.25;
    // reset with a pair offered (R4: dropped), then a known sequence
    step(1, 1, 8'h00, 8'h01, 8'hFF, "");
    step(1, 1, 8'h00, 8'h01, 8'hFF, "");
    step(0, 1, 8'h02, 8'h03, 8'hFF, "");
    step(0, 1, 8'h04, 8'h05, 8'hFF, "");
    // hold with enable low (R5)
    step(0, 0, 8'hAA, 8'h55, 8'hFF, "");
    step(0, 0, 8'h11, 8'h22, 8'hFF, "");
    // rst_val moves while reset is low (R7)
    step(0, 0, 8'h33, 8'h44, 8'h5A, "R7");
    step(0, 1, 8'h66, 8'h77, 8'hC3, "R7");
    step(0, 1, 8'h88, 8'h99, 8'h0F, "R7");
    // reset and enable together (R6)
    step(1, 1, 8'hDE, 8'hAD, 8'h3C, "");
    step(1, 1, 8'hBE, 8'hEF, 8'h3C, "");
    step(1, 0, 8'hBE, 8'hEF, 8'h3C, "");
    step(0, 1, 8'h12, 8'h34, 8'h3C, "");
    // boundary words
    step(0, 1, 8'hFF, 8'h00, 8'h00, "");
    step(0, 1, 8'h00, 8'hFF, 8'h00, "");
    for (int k = 0; k < 400; k++) begin
      step(($urandom % 16) == 0, ($urandom % 4) != 0, W'($urandom), W'($urandom),
           W'($urandom), "");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule